// File: doc/BRIEF.md
# Priority Port Pin Crossbar

This block places a small set of on-chip peripheral signals onto 24 general-purpose pins, arranged as three ports of eight. Pin index is port times eight plus bit. Three configuration registers say which peripheral signals are wanted. The enabled signals are packed onto consecutive pins in a fixed priority order, starting at pin 0. Because of this packing, the pin a signal lands on depends on how many higher-priority signals are enabled. Every pin that no signal claims is driven from its port latch bit.

Software writes the registers through a plain write/read port. The pin map is built combinationally from the stored register values, so a write changes the map from the cycle after its clock edge. For every pin, the block produces the output value, the output enable and the weak pull-up request. It also returns each claimed pin's value to the peripheral input that owns the pin. The interface is pure control: there is no stream and no handshake.

Top module: `pin_crossbar`

## Requirements
- R1: After reset, all three configuration registers read 0x00. Every pin then follows its latch bit, and every peripheral sense output is 1.
- R2: A write to address 0 or 1 stores all eight bits, which then read back. Address 3 reads 0x00 and ignores writes.
- R3: At address 2, only bits 7, 6 and 0 are stored. Bits 5 to 1 always read 0, whatever was written.
- R4: While routing-enable (bit 6 of address 2) is 0, no peripheral signal takes a pin. Every pin follows its latch, and every sense output is 1.
- R5: While routing is enabled, the enabled signals take pins 0, 1, 2 and upward in this order:
  - two-wire data, then two-wire clock, when bit 0 of address 0 is set;
  - capture output 0, then capture output 1, where output k is present when the 3-bit count in address 0 bits 5:3 is greater than k;
  - comparator output, when bit 7 of address 0 is set;
  - interrupt-0 input, when bit 2 of address 1 is set;
  - convert-start input, when bit 0 of address 2 is set.
- R6: An unclaimed pin drives its latch bit. Its enable is high when the pin is push-pull or the latch bit is 0.
- R7: A pin carrying a capture or comparator output drives that peripheral's value. Its enable is high when the pin is push-pull or the value is 0. A two-wire pin is always open-drain: its enable is the inverse of the value.
- R8: A pin claimed by interrupt-0 or convert-start drives 0 with its enable low. Each two-wire or input sense output returns the value of its own pin, and returns 1 when it has no pin.
- R9: The weak pull-up request of each pin is high only when bit 7 of address 2 is 0 and the pin is not push-pull.
- R10: A register write changes the pin map from the first cycle after its write edge. The cycle in which the write is presented still shows the old map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| latch_i | input | 24 | Port latch bits, one per pin |
| pp_mode_i | input | 24 | 1 = pin is push-pull |
| pin_in_i | input | 24 | Pin pad input values |
| pin_out_o | output | 24 | Pin output values |
| pin_oe_o | output | 24 | Pin output enables |
| pin_pu_o | output | 24 | Weak pull-up requests |
| tw_data_drive | input | 1 | Two-wire data value from peripheral |
| tw_clk_drive | input | 1 | Two-wire clock value from peripheral |
| cap_drive | input | 2 | Capture output values |
| cmp_drive | input | 1 | Comparator output value |
| tw_data_sense | output | 1 | Two-wire data pin value to peripheral |
| tw_clk_sense | output | 1 | Two-wire clock pin value to peripheral |
| irq0_sense | output | 1 | Interrupt-0 pin value |
| conv_sense | output | 1 | Convert-start pin value |

## Verification
The two functions that can fall in the same cycle are a register write and the routing of pins whose owner that write moves. The bench presents a write that turns routing on while the latch pattern differs from the peripheral values. In the presented cycle it expects the old latch-driven pins, and in the cycle after the edge it expects the new assignment. A sweep over all 256 combinations of the enable fields then checks every pin's value, enable and pull-up, and all sense outputs, against a placement model held in the bench, under two pin patterns per configuration.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int NRES = 7;
  localparam int NCAP = 2;
  localparam int RES_TWD  = 0;
  localparam int RES_TWC  = 1;
  localparam int RES_CAP0 = 2;
  localparam int RES_CMP  = 4;
  localparam int RES_IRQ  = 5;
  localparam int RES_CNV  = 6;
  localparam logic [7:0] CFG2_KEEP = 8'hC1;

  typedef enum logic [1:0] {K_OPEN_DRAIN, K_OUTPUT, K_INPUT} res_kind_e;

  function automatic res_kind_e kind_of(input int r);
    if (r == RES_TWD || r == RES_TWC) return K_OPEN_DRAIN;
    if (r == RES_IRQ || r == RES_CNV) return K_INPUT;
    return K_OUTPUT;
  endfunction
endpackage

// File: rtl/pxb_regs.sv
module pxb_regs
  import pxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic [7:0] cfg0_q,
  output logic [7:0] cfg1_q,
  output logic [7:0] cfg2_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      cfg2_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: cfg0_q <= wdata;
        2'd1: cfg1_q <= wdata;
        2'd2: cfg2_q <= wdata & CFG2_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0: rd_data = cfg0_q;
      2'd1: rd_data = cfg1_q;
      2'd2: rd_data = cfg2_q;
      default: rd_data = '0;
    endcase
  end

  AST_CFG0_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 2'd0) |=> (cfg0_q == $past(wdata))); // R2
  AST_CFG2_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 2'd2) |=> (cfg2_q[5:1] == 5'd0 && cfg2_q[0] == $past(wdata[0]))); // R3
endmodule

// File: rtl/pxb_alloc.sv
module pxb_alloc
  import pxb_pkg::*;
#(
  parameter int NPIN = 24,
  parameter int PW   = $clog2(NPIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xbar_en,
  input  logic                     tw_en,
  input  logic [2:0]               cap_cnt,
  input  logic                     cmp_en,
  input  logic                     irq_en,
  input  logic                     cnv_en,
  output logic [NRES-1:0]          res_on,
  output logic [NRES-1:0][PW-1:0]  res_pin
);
  logic [NRES-1:0] want;

  always_comb begin
    want = '0;
    want[RES_TWD] = xbar_en & tw_en;
    want[RES_TWC] = xbar_en & tw_en;
    for (int c = 0; c < NCAP; c++)
      want[RES_CAP0 + c] = xbar_en && (int'(cap_cnt) > c);
    want[RES_CMP] = xbar_en & cmp_en;
    want[RES_IRQ] = xbar_en & irq_en;
    want[RES_CNV] = xbar_en & cnv_en;
  end

  // Prefix count: each enabled signal lands on the number of enabled signals ahead of it.
  always_comb begin
    int cnt;
    cnt     = 0;
    res_on  = '0;
    res_pin = '0;
    for (int r = 0; r < NRES; r++) begin
      if (want[r]) begin
        if (cnt < NPIN) begin
          res_on[r]  = 1'b1;
          res_pin[r] = PW'(cnt);
        end
        cnt++;
      end
    end
  end

  for (genvar r = 1; r < NRES; r++) begin : g_order
    AST_PACKED_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (res_on[r] && res_on[r-1]) |-> (res_pin[r] == res_pin[r-1] + PW'(1))); // R5
  end
endmodule

// File: rtl/pxb_pinmux.sv
module pxb_pinmux
  import pxb_pkg::*;
#(
  parameter int NPIN = 24,
  parameter int PW   = $clog2(NPIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRES-1:0]          res_on,
  input  logic [NRES-1:0][PW-1:0]  res_pin,
  input  logic [NRES-1:0]          res_drive,
  input  logic                     pu_off,
  input  logic [NPIN-1:0]          latch_i,
  input  logic [NPIN-1:0]          pp_mode_i,
  input  logic [NPIN-1:0]          pin_in_i,
  output logic [NPIN-1:0]          pin_out_o,
  output logic [NPIN-1:0]          pin_oe_o,
  output logic [NPIN-1:0]          pin_pu_o,
  output logic [NRES-1:0]          res_sense
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [NRES-1:0] hit;

    always_comb begin
      for (int r = 0; r < NRES; r++)
        hit[r] = res_on[r] && (res_pin[r] == PW'(g));
    end

    always_comb begin
      pin_out_o[g] = latch_i[g];
      pin_oe_o[g]  = pp_mode_i[g] | ~latch_i[g];
      for (int r = 0; r < NRES; r++) begin
        if (hit[r]) begin
          case (kind_of(r))
            K_OPEN_DRAIN: begin
              pin_out_o[g] = res_drive[r];
              pin_oe_o[g]  = ~res_drive[r];
            end
            K_OUTPUT: begin
              pin_out_o[g] = res_drive[r];
              pin_oe_o[g]  = pp_mode_i[g] | ~res_drive[r];
            end
            default: begin
              pin_out_o[g] = 1'b0;
              pin_oe_o[g]  = 1'b0;
            end
          endcase
        end
      end
    end

    assign pin_pu_o[g] = ~pu_off & ~pp_mode_i[g];

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit)); // R5
    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n) (hit[RES_IRQ] || hit[RES_CNV]) |-> !pin_oe_o[g]); // R8
  end

  for (genvar r = 0; r < NRES; r++) begin : g_sense
    assign res_sense[r] = res_on[r] ? pin_in_i[res_pin[r]] : 1'b1;
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import pxb_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int NPIN  = NPORT * 8,
  parameter int PW    = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_data,
  input  logic [NPIN-1:0]  latch_i,
  input  logic [NPIN-1:0]  pp_mode_i,
  input  logic [NPIN-1:0]  pin_in_i,
  output logic [NPIN-1:0]  pin_out_o,
  output logic [NPIN-1:0]  pin_oe_o,
  output logic [NPIN-1:0]  pin_pu_o,
  input  logic             tw_data_drive,
  input  logic             tw_clk_drive,
  input  logic [NCAP-1:0]  cap_drive,
  input  logic             cmp_drive,
  output logic             tw_data_sense,
  output logic             tw_clk_sense,
  output logic             irq0_sense,
  output logic             conv_sense
);
  logic [7:0] cfg0_q, cfg1_q, cfg2_q;
  logic [NRES-1:0]         res_on;
  logic [NRES-1:0][PW-1:0] res_pin;
  logic [NRES-1:0]         res_drive;
  logic [NRES-1:0]         res_sense;
  logic                    unused_bits;

  pxb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q)
  );

  pxb_alloc #(.NPIN(NPIN), .PW(PW)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .xbar_en(cfg2_q[6]), .tw_en(cfg0_q[0]), .cap_cnt(cfg0_q[5:3]),
    .cmp_en(cfg0_q[7]), .irq_en(cfg1_q[2]), .cnv_en(cfg2_q[0]),
    .res_on(res_on), .res_pin(res_pin)
  );

  always_comb begin
    res_drive = '0;
    res_drive[RES_TWD] = tw_data_drive;
    res_drive[RES_TWC] = tw_clk_drive;
    for (int c = 0; c < NCAP; c++)
      res_drive[RES_CAP0 + c] = cap_drive[c];
    res_drive[RES_CMP] = cmp_drive;
  end

  pxb_pinmux #(.NPIN(NPIN), .PW(PW)) u_mux (
    .clk(clk), .rst_n(rst_n), .res_on(res_on), .res_pin(res_pin),
    .res_drive(res_drive), .pu_off(cfg2_q[7]),
    .latch_i(latch_i), .pp_mode_i(pp_mode_i), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o),
    .res_sense(res_sense)
  );

  assign tw_data_sense = res_sense[RES_TWD];
  assign tw_clk_sense  = res_sense[RES_TWC];
  assign irq0_sense    = res_sense[RES_IRQ];
  assign conv_sense    = res_sense[RES_CNV];

  assign unused_bits = ^{cfg0_q[6], cfg0_q[2:1], cfg1_q[7:3], cfg1_q[1:0],
                         cfg2_q[5:1], res_sense[RES_CMP:RES_CAP0]};

  AST_OFF_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) !cfg2_q[6] |-> (pin_out_o == latch_i && irq0_sense && conv_sense)); // R4
  AST_PULLUP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) cfg2_q[7] |-> (pin_pu_o == '0)); // R9
endmodule

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [23:0] latch_i = '0, pp_mode_i = '0, pin_in_i = '0;
  logic [23:0] pin_out_o, pin_oe_o, pin_pu_o;
  logic tw_data_drive = 1'b0, tw_clk_drive = 1'b0, cmp_drive = 1'b0;
  logic [1:0] cap_drive = '0;
  logic tw_data_sense, tw_clk_sense, irq0_sense, conv_sense;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] m0 = '0, m1 = '0, m2 = '0;

  always #5 clk = ~clk;

  pin_crossbar u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .latch_i(latch_i), .pp_mode_i(pp_mode_i), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o),
    .tw_data_drive(tw_data_drive), .tw_clk_drive(tw_clk_drive), .cap_drive(cap_drive),
    .cmp_drive(cmp_drive), .tw_data_sense(tw_data_sense), .tw_clk_sense(tw_clk_sense),
    .irq0_sense(irq0_sense), .conv_sense(conv_sense)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) m0 = d;
    else if (a == 2'd1) m1 = d;
    else if (a == 2'd2) m2 = d & 8'hC1;
  endtask

  task automatic read_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  // Bench placement model, built from R5..R9
  task automatic expect_pins(output logic [23:0] eo, output logic [23:0] ee,
                             output logic [23:0] ep, output logic [3:0] es);
    int own [24];
    int k;
    logic [6:0] drv;
    drv = {1'b0, 1'b0, cmp_drive, cap_drive[1], cap_drive[0], tw_clk_drive, tw_data_drive};
    for (int p = 0; p < 24; p++) own[p] = -1;
    k = 0;
    if (m2[6]) begin
      if (m0[0]) begin own[k] = 0; own[k+1] = 1; k += 2; end
      for (int c = 0; c < 2; c++) if (int'(m0[5:3]) > c) begin own[k] = 2 + c; k++; end
      if (m0[7]) begin own[k] = 4; k++; end
      if (m1[2]) begin own[k] = 5; k++; end
      if (m2[0]) begin own[k] = 6; k++; end
    end
    es = 4'b1111;
    for (int p = 0; p < 24; p++) begin
      ep[p] = ~m2[7] & ~pp_mode_i[p];
      if (own[p] < 0) begin
        eo[p] = latch_i[p]; ee[p] = pp_mode_i[p] | ~latch_i[p];
      end else if (own[p] <= 1) begin
        eo[p] = drv[own[p]]; ee[p] = ~drv[own[p]];
      end else if (own[p] <= 4) begin
        eo[p] = drv[own[p]]; ee[p] = pp_mode_i[p] | ~drv[own[p]];
      end else begin
        eo[p] = 1'b0; ee[p] = 1'b0;
      end
      if (own[p] == 0) es[0] = pin_in_i[p];
      if (own[p] == 1) es[1] = pin_in_i[p];
      if (own[p] == 5) es[2] = pin_in_i[p];
      if (own[p] == 6) es[3] = pin_in_i[p];
    end
  endtask

  task automatic check_pins(input string tag);
    logic [23:0] eo, ee, ep;
    logic [3:0] es;
    expect_pins(eo, ee, ep, es);
    check({tag, " out R5 R6 R7"}, {8'd0, pin_out_o}, {8'd0, eo});
    check({tag, " oe R7 R8"}, {8'd0, pin_oe_o}, {8'd0, ee});
    check({tag, " pullup R9"}, {8'd0, pin_pu_o}, {8'd0, ep});
    check({tag, " sense R8"}, {28'd0, conv_sense, irq0_sense, tw_clk_sense, tw_data_sense},
          {28'd0, es});
  endtask

  task automatic set_pattern(input int seed);
    latch_i   = 24'h5A3C96 ^ (24'(seed) * 24'h013579);
    pp_mode_i = 24'hC30F71 ^ (24'(seed) * 24'h02468B);
    pin_in_i  = 24'h9E1B4D ^ (24'(seed) * 24'h0F1E2D);
    {cmp_drive, cap_drive, tw_clk_drive, tw_data_drive} = 5'(seed * 7 + 3);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_pattern(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    read_check("R1 reg0 reset", 2'd0, 8'h00);
    read_check("R1 reg1 reset", 2'd1, 8'h00);
    read_check("R1 reg2 reset", 2'd2, 8'h00);
    check_pins("R1 reset");

    // R2: readback, address 3
    write_reg(2'd0, 8'hA7);
    write_reg(2'd1, 8'h5E);
    write_reg(2'd3, 8'hFF);
    read_check("R2 reg0", 2'd0, 8'hA7);
    read_check("R2 reg1", 2'd1, 8'h5E);
    read_check("R2 reg3", 2'd3, 8'h00);
    // R3: unused bits of reg2
    write_reg(2'd2, 8'h3E);
    read_check("R3 reg2 unused", 2'd2, 8'h00);
    // R4: disabled, many enables set
    check_pins("R4 disabled");

    // R10 + example: reg0=0x11, reg2 goes 0x00 -> 0x40
    write_reg(2'd1, 8'h00);
    write_reg(2'd0, 8'h11);
    set_pattern(9);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h40;
    #1;
    check("R10 presented cycle old map", {8'd0, pin_out_o}, {8'd0, latch_i});
    @(negedge clk);
    wr_en = 1'b0;
    m2 = 8'h40;
    check_pins("R10 after edge");
    check("R5 example1 pin0 data open-drain", {31'd0, pin_oe_o[0]}, {31'd0, ~tw_data_drive});
    check("R5 example1 pin3 cap1", {31'd0, pin_out_o[3]}, {31'd0, cap_drive[1]});

    // Example 2: comparator, irq0, convert-start on pins 0..2
    write_reg(2'd0, 8'h80);
    write_reg(2'd1, 8'h04);
    write_reg(2'd2, 8'h41);
    check("R8 example2 pins1..2 undriven", {30'd0, pin_oe_o[2:1]}, 32'd0);
    check("R8 example2 irq0 sense", {31'd0, irq0_sense}, {31'd0, pin_in_i[1]});
    check("R8 example2 conv sense", {31'd0, conv_sense}, {31'd0, pin_in_i[2]});
    check_pins("R5 example2");

    // Full sweep of the enable fields
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b0, b1, b2;
      b0 = {i[4], i[2], i[3:1], i[5], i[6], i[0]};
      b1 = {i[7:3], i[5], i[1:0]};
      b2 = {i[1] ^ i[4], i[7], 5'b10110, i[6]};
      write_reg(2'd0, b0);
      write_reg(2'd1, b1);
      write_reg(2'd2, b2);
      read_check("R3 sweep reg2", 2'd2, b2 & 8'hC1);
      for (int s = 0; s < 2; s++) begin
        set_pattern(i * 3 + s);
        #1;
        check_pins("sweep");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule